// File: doc/BRIEF.md
# Display Row Buffer Sequencer

This block decides which row buffer an on-screen display engine fetches from on each scan line. Software writes an 8-bit control byte. Two of its bits, display-on and enable, select the working mode. Full display runs only when both bits are set. The other bits set transfer enable, double scan, non-interlaced counting, translucency and fast pixel clock. The programmed first-buffer address and event line come in on dedicated input ports.

A 10-bit scan line counter steps on horizontal sync pulses and is cleared by vertical sync. On the sync that ends the programmed event line, the block pulses an interrupt. It then either moves the buffer pointer on by one row buffer, or marks the current buffer as consumed so that border colour is shown. The block also gates the pixel clock and the translucency output.

All inputs are synchronous to `clk`. Sync inputs are single-cycle pulses.

Top module: `osd_row_seq`

## Requirements
- R1: The control register resets to 00h. Its bit positions are: bit 0 display-on, bit 1 enable, bit 2 transfer enable, bit 3 double scan, bit 4 non-interlaced, bit 5 translucency enable, bit 6 fast pixel clock. Bit 7 is reserved and always reads 0.
- R2: When a write moves (display-on, enable) from any other value to (1,1), `first_addr` is loaded into `buf_addr` at that clock edge.
- R3: Writing (1,1) again while full display is already active does not reload `buf_addr`.
- R4: `irq` goes high for exactly one cycle after a counter-advancing `hsync` that arrives while `scan_line` equals `event_line`. This happens whatever the transfer enable value.
- R5: On such a match with transfer enable 1 in full display, `buf_addr` advances by ROW_BYTES (64), and `border_sel` goes to 0.
- R6: On such a match with transfer enable 0, `buf_addr` is unchanged and `border_sel` goes to 1. It stays 1 until the next swap or the next entry into full display.
- R7: With fast pixel clock 0, `pix_ce` alternates every cycle. With fast pixel clock 1, `pix_ce` is constantly 1.
- R8: With translucency enable 0, `tslu` stays 0. With it set to 1, `tslu` equals `bg_active`.
- R9: With non-interlaced 1, every `vsync` clears `scan_line`. With non-interlaced 0, each `vsync` toggles `field_odd`, and only a `vsync` that begins the even field clears `scan_line`.
- R10: With double scan 1, `scan_line` advances once per two `hsync` pulses. The pairing restarts at each `vsync`.
- R11: Outside full display, `border_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| first_addr | input | ADDR_W | First row buffer address |
| event_line | input | LINE_W | Scan line that triggers the event |
| hsync | input | 1 | Line sync pulse |
| vsync | input | 1 | Field sync pulse |
| bg_active | input | 1 | Real-time background-active signal |
| buf_addr | output | ADDR_W | Active row buffer address |
| border_sel | output | 1 | Show border colour |
| tslu | output | 1 | Translucency output |
| pix_ce | output | 1 | Pixel clock enable |
| irq | output | 1 | Event-line interrupt pulse |
| scan_line | output | LINE_W | Current scan line count |
| field_odd | output | 1 | Odd field flag in interlaced counting |

## Verification
A wrong pointer state shows on `buf_addr` in the cycle after the entry write or after the matching sync. A stuck consumed flag shows as `border_sel` high during full display. A counter that counts wrongly moves the interrupt to the wrong line, which is visible one cycle after that line's closing `hsync`. `scan_line` and `field_odd` show a fault in double-scan pairing or field clearing within one sync pulse.

// File: rtl/osd_row_seq.sv
module osd_row_seq #(
  parameter int ADDR_W    = 12,
  parameter int LINE_W    = 10,
  parameter int ROW_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [LINE_W-1:0] event_line,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              bg_active,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              border_sel,
  output logic              tslu,
  output logic              pix_ce,
  output logic              irq,
  output logic [LINE_W-1:0] scan_line,
  output logic              field_odd
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ROW_BYTES);

  logic [6:0] ctl_q;
  logic       used_q, dbl_ph, pix_tgl;

  wire full_now  = ctl_q[0] & ctl_q[1];
  wire full_next = ctl_wdata[0] & ctl_wdata[1];
  wire enter     = ctl_we & full_next & ~full_now;
  wire xfer_en   = ctl_q[2];
  wire dbl       = ctl_q[3];
  wire nonint    = ctl_q[4];
  wire line_step = hsync & ~vsync & (~dbl | dbl_ph);
  wire match     = line_step & (scan_line == event_line);

  assign ctl_rdata  = {1'b0, ctl_q};
  assign border_sel = ~full_now | used_q;
  assign tslu       = ctl_q[5] & bg_active;
  assign pix_ce     = ctl_q[6] | pix_tgl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      buf_addr  <= '0;
      used_q    <= 1'b0;
      irq       <= 1'b0;
      scan_line <= '0;
      field_odd <= 1'b0;
      dbl_ph    <= 1'b0;
      pix_tgl   <= 1'b0;
    end else begin
      pix_tgl <= ~pix_tgl;
      irq     <= match;
      if (ctl_we) ctl_q <= ctl_wdata[6:0];

      if (vsync) begin
        dbl_ph    <= 1'b0;
        field_odd <= nonint ? 1'b0 : ~field_odd;
        if (nonint || field_odd) scan_line <= '0;
      end else if (hsync) begin
        if (dbl) dbl_ph <= ~dbl_ph;
        if (line_step) scan_line <= scan_line + 1'b1;
      end

      if (enter) begin
        buf_addr <= first_addr;
        used_q   <= 1'b0;
      end else if (match && full_now) begin
        if (xfer_en) begin
          buf_addr <= buf_addr + STEP;
          used_q   <= 1'b0;
        end else begin
          used_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_row_seq_chk.sv
module osd_row_seq_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctl_rdata,
  input logic              vsync,
  input logic              border_sel,
  input logic              tslu,
  input logic              pix_ce,
  input logic              irq,
  input logic [LINE_W-1:0] scan_line
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ctl_rdata[7] == 1'b0); // R1
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R4
  AST_FAST_PIX: assert property (@(posedge clk) disable iff (!rst_n) ctl_rdata[6] |-> pix_ce); // R7
  AST_TSLU_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !ctl_rdata[5] |-> !tslu); // R8
  AST_VSYNC_CLR: assert property (@(posedge clk) disable iff (!rst_n) (vsync && ctl_rdata[4]) |=> scan_line == '0); // R9
  AST_BORDER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(ctl_rdata[0] && ctl_rdata[1]) |-> border_sel); // R11
endmodule

bind osd_row_seq osd_row_seq_chk #(.LINE_W(LINE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .vsync(vsync),
  .border_sel(border_sel), .tslu(tslu), .pix_ce(pix_ce), .irq(irq),
  .scan_line(scan_line)
);

// File: tb/osd_row_seq_tb_top.sv
module osd_row_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [11:0] first_addr = '0;
  logic [9:0] event_line = '0;
  logic hsync = 1'b0, vsync = 1'b0, bg_active = 1'b0;
  logic [11:0] buf_addr;
  logic border_sel, tslu, pix_ce, irq, field_odd;
  logic [9:0] scan_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_row_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .first_addr(first_addr), .event_line(event_line),
    .hsync(hsync), .vsync(vsync), .bg_active(bg_active), .buf_addr(buf_addr),
    .border_sel(border_sel), .tslu(tslu), .pix_ce(pix_ce), .irq(irq),
    .scan_line(scan_line), .field_odd(field_odd)
  );

  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hFF_7F, 16'h80_00, 16'h55_55, 16'hAA_2A, 16'h13_13, 16'h00_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic hs();
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
  endtask

  task automatic vs();
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_rdata == 8'h00, "R1 reset", ctl_rdata, 0);
    chk(buf_addr == 0 && irq == 0 && scan_line == 0, "R1 reset outputs", buf_addr, 0);
    chk(border_sel == 1'b1, "R11 reset border", border_sel, 1);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][15:8]);
      chk(ctl_rdata == VEC[i][7:0], "R1 readback", ctl_rdata, VEC[i][7:0]);
    end

    wr(8'h00);
    first_addr = 12'h100; event_line = 10'd3;
    wr(8'h13);
    chk(buf_addr == 12'h100, "R2 entry load", buf_addr, 12'h100);
    chk(border_sel == 1'b0, "R11 full border off", border_sel, 0);
    first_addr = 12'h200;
    wr(8'h13);
    chk(buf_addr == 12'h100, "R3 no reload", buf_addr, 12'h100);

    vs();
    chk(scan_line == 0, "R9 vsync clear", scan_line, 0);
    for (int i = 0; i < 3; i++) begin
      hs();
      chk(irq == 1'b0, "R4 no early irq", irq, 0);
    end
    chk(scan_line == 3, "R9 line count", scan_line, 3);
    hs();
    chk(irq == 1'b1, "R4 irq xfer off", irq, 1);
    chk(buf_addr == 12'h100, "R6 no swap", buf_addr, 12'h100);
    chk(border_sel == 1'b1, "R6 border shown", border_sel, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R4 one cycle", irq, 0);
    chk(border_sel == 1'b1, "R6 border held", border_sel, 1);

    wr(8'h17);
    chk(buf_addr == 12'h100, "R3 no reload on rewrite", buf_addr, 12'h100);
    vs();
    repeat (3) hs();
    hs();
    chk(irq == 1'b1, "R4 irq xfer on", irq, 1);
    chk(buf_addr == 12'h140, "R5 swap", buf_addr, 12'h140);
    chk(border_sel == 1'b0, "R5 border off", border_sel, 0);

    p0 = pix_ce;
    @(negedge clk);
    chk(pix_ce == ~p0, "R7 divided pix", pix_ce, ~p0);
    @(negedge clk);
    chk(pix_ce == p0, "R7 divided pix", pix_ce, p0);
    wr(8'h57);
    chk(pix_ce == 1'b1, "R7 fast pix", pix_ce, 1);
    @(negedge clk);
    chk(pix_ce == 1'b1, "R7 fast pix", pix_ce, 1);

    bg_active = 1'b1;
    @(negedge clk);
    chk(tslu == 1'b0, "R8 tslu idle", tslu, 0);
    wr(8'h77);
    chk(tslu == 1'b1, "R8 tslu follows", tslu, 1);
    bg_active = 1'b0;
    @(negedge clk);
    chk(tslu == 1'b0, "R8 tslu follows low", tslu, 0);

    event_line = 10'd500;
    wr(8'h1F);
    vs();
    hs();
    chk(scan_line == 0, "R10 first hsync held", scan_line, 0);
    hs();
    chk(scan_line == 1, "R10 second hsync steps", scan_line, 1);
    hs(); hs();
    chk(scan_line == 2, "R10 pair", scan_line, 2);

    wr(8'h17);
    vs();
    chk(scan_line == 0 && field_odd == 0, "R9 nonint vsync", scan_line, 0);
    wr(8'h07);
    hs(); hs();
    vs();
    chk(field_odd == 1'b1, "R9 field toggle", field_odd, 1);
    chk(scan_line == 2, "R9 odd field keeps count", scan_line, 2);
    hs();
    chk(scan_line == 3, "R9 continue count", scan_line, 3);
    vs();
    chk(field_odd == 1'b0 && scan_line == 0, "R9 even field clears", scan_line, 0);

    wr(8'h00);
    chk(border_sel == 1'b1, "R11 exit full", border_sel, 1);
    wr(8'h03);
    chk(buf_addr == 12'h200, "R2 re-entry load", buf_addr, 12'h200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule